// File: doc/BRIEF.md
# Multi-bank page-mode DRAM controller

This block turns single-beat read and write requests from an internal bus into the strobe sequences that an asynchronous fast-page-mode or EDO DRAM array needs. A request carries a 64-bit word address (1 GB of byte storage in total), 64 bits of write data and eight byte enables. The controller picks one of eight banks from the top address bits. It places the row and then the column on a shared 13-bit multiplexed address bus, with two internal bank-address bits alongside. It pulses that bank's row strobe and the per-byte column strobes, and drives the single shared write enable.

Each data byte has one odd-parity bit. The block generates these bits on writes. On reads it checks them against the data it captures, returning the read word with a per-byte error vector and a summary error flag. A free-running interval timer requests a refresh of all banks, using column-before-row strobe order. The refresh takes the array only when the controller is idle, and it goes ahead of any request that is waiting. All delays are parameters counted in clock cycles.

Top module: `dram_pm_ctrl`

## Requirements
- R1: `req_ready` is high only when no access or refresh is running and no refresh is pending. A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- R2: Word-address bits [26:24] select the bank. During an access only that bank's `dram_ras_n` line is low, and all the others stay high.
- R3: In the cycle after acceptance and until the column strobes fall, `dram_ma` carries the row (word address [23:11]). While the column strobes are low it carries the column (word address [8:0], zero-extended). For the whole access `dram_ba` carries word address [10:9].
- R4: The row strobe falls one cycle after acceptance. The column strobes fall T_RCD cycles after that and stay low for T_CAS cycles. Then every strobe rises together and a precharge of T_RP cycles follows before the block is idle again.
- R5: On a write, column strobe i is low exactly when `req_be[i]` is set (lane i is data bits [8i+7:8i]). On a read, all eight column strobes are low.
- R6: During a write's column-strobe window, `dram_we_n` is low, `dram_dq_oe` is high and `dram_dq_out` equals the request's write data. Outside that window `dram_we_n` is high and `dram_dq_oe` is low.
- R7: While a write drives the data, `dram_par_out[i]` is the odd-parity bit of data lane i: the nine bits together hold an odd number of ones.
- R8: Read data is sampled from `dram_dq_in` in the last cycle of the column-strobe pulse. `rsp_valid` is high for exactly one cycle, the first cycle after the strobes rise, with that data on `rsp_rdata`.
- R9: Alongside `rsp_valid`, `rsp_perr[i]` is set when lane i and `dram_par_in[i]` together hold an even number of ones. `rsp_perr_any` is the OR of those bits and is low whenever `rsp_valid` is low.
- R10: A refresh becomes pending every REF_INTERVAL cycles after reset. It runs as: all column strobes low for one cycle, then all row strobes also low for T_REF_RAS cycles with `dram_we_n` high, then all strobes high and a T_RP precharge.
- R11: A pending refresh never interrupts an access. It starts on the first idle cycle, and if a request is waiting then, the refresh goes first.
- R12: During reset and straight after it, every strobe and `dram_we_n` is high, `dram_dq_oe` and `rsp_valid` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 27 | 64-bit word address: bank [26:24], row [23:11], internal bank [10:9], column [8:0] |
| req_wdata | input | 64 | Write data |
| req_be | input | 8 | Byte enables for writes |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 64 | Captured read data |
| rsp_perr | output | 8 | Per-lane parity error |
| rsp_perr_any | output | 1 | Any lane in error |
| dram_ma | output | 13 | Multiplexed row/column address |
| dram_ba | output | 2 | Internal bank address |
| dram_ras_n | output | 8 | Row strobes, one per bank, active low |
| dram_cas_n | output | 8 | Column strobes, one per byte lane, active low |
| dram_we_n | output | 1 | Shared write enable, active low |
| dram_dq_oe | output | 1 | Data bus output enable |
| dram_dq_out | output | 64 | Data driven to memory |
| dram_dq_in | input | 64 | Data returned by memory |
| dram_par_out | output | 8 | Parity driven to memory |
| dram_par_in | input | 8 | Parity returned by memory |

## Verification
Most internal faults show up at the strobe pins in the same cycle. A wrong phase or a miscounted delay shifts a strobe edge by at least one clock, and a bad bank decode lowers the wrong row line. A wrong byte mask shows as a wrong column-strobe pattern. Capture-time and parity faults appear only on the cycle `rsp_valid` is high, so the memory side changes the data except in the last column cycle, and it corrupts chosen parity lanes. Refresh timer faults appear as a strobe pattern starting early or late against a free-running interval count.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_ROW  = 3'd1,
    S_RCD  = 3'd2,
    S_CAS  = 3'd3,
    S_PRE  = 3'd4,
    S_RCAS = 3'd5,
    S_RRAS = 3'd6
  } dpc_state_t;

  function automatic int dpc_max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/dpc_addr_split.sv
module dpc_addr_split #(
  parameter int BANKS   = 8,
  parameter int MA_W    = 13,
  parameter int ROW_W   = 13,
  parameter int COL_W   = 9,
  parameter int IBANK_W = 2,
  localparam int BSEL_W = $clog2(BANKS),
  localparam int ADDR_W = COL_W + IBANK_W + ROW_W + BSEL_W
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [BANKS-1:0]   bank_oh,
  output logic [MA_W-1:0]    row_ma,
  output logic [MA_W-1:0]    col_ma,
  output logic [IBANK_W-1:0] ibank
);
  localparam int IB_LSB  = COL_W;
  localparam int ROW_LSB = IB_LSB + IBANK_W;
  localparam int BS_LSB  = ROW_LSB + ROW_W;

  logic [BSEL_W-1:0] bsel;
  assign bsel = addr[BS_LSB +: BSEL_W];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign bank_oh[b] = (bsel == BSEL_W'(b));
  end

  assign row_ma = MA_W'(addr[ROW_LSB +: ROW_W]);
  assign col_ma = MA_W'(addr[COL_W-1:0]);
  assign ibank  = addr[IB_LSB +: IBANK_W];
endmodule

// File: rtl/dpc_lane_parity.sv
module dpc_lane_parity #(
  parameter int LANES = 8
) (
  input  logic [LANES*8-1:0] data,
  output logic [LANES-1:0]   odd_bit
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign odd_bit[i] = ~(^data[8*i +: 8]);
  end
endmodule

// File: rtl/dpc_refresh_timer.sv
module dpc_refresh_timer #(
  parameter int INTERVAL = 780,
  localparam int TW = $clog2(INTERVAL + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic ack,
  output logic pending
);
  logic [TW-1:0] cnt;
  logic          tick;

  assign tick = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= TW'(INTERVAL - 1);
      pending <= 1'b0;
    end else begin
      cnt     <= tick ? TW'(INTERVAL - 1) : cnt - 1'b1;
      pending <= (pending & ~ack) | tick;
    end
  end
endmodule

// File: rtl/dram_pm_ctrl.sv
module dram_pm_ctrl
  import dpc_pkg::*;
#(
  parameter int BANKS        = 8,
  parameter int LANES        = 8,
  parameter int MA_W         = 13,
  parameter int ROW_W        = 13,
  parameter int COL_W        = 9,
  parameter int IBANK_W      = 2,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 3,
  parameter int T_RP         = 2,
  parameter int T_REF_RAS    = 4,
  parameter int REF_INTERVAL = 780,
  localparam int DATA_W = LANES * 8,
  localparam int BSEL_W = $clog2(BANKS),
  localparam int ADDR_W = COL_W + IBANK_W + ROW_W + BSEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [LANES-1:0]   req_be,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic [LANES-1:0]   rsp_perr,
  output logic               rsp_perr_any,
  output logic [MA_W-1:0]    dram_ma,
  output logic [IBANK_W-1:0] dram_ba,
  output logic [BANKS-1:0]   dram_ras_n,
  output logic [LANES-1:0]   dram_cas_n,
  output logic               dram_we_n,
  output logic               dram_dq_oe,
  output logic [DATA_W-1:0]  dram_dq_out,
  input  logic [DATA_W-1:0]  dram_dq_in,
  output logic [LANES-1:0]   dram_par_out,
  input  logic [LANES-1:0]   dram_par_in
);
  localparam int CNT_MAX = dpc_max4(T_RCD, T_CAS, T_RP, T_REF_RAS);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  dpc_state_t        st;
  logic [CNT_W-1:0]  cnt;
  logic              cnt_done;

  logic [BANKS-1:0]   dec_bank;
  logic [MA_W-1:0]    dec_row;
  logic [MA_W-1:0]    dec_col;
  logic [IBANK_W-1:0] dec_ib;
  logic [LANES-1:0]   wr_par;
  logic [LANES-1:0]   rd_par_calc;
  logic [LANES-1:0]   rd_err;

  logic               ref_pend;
  logic               ref_ack;

  logic               wr_q;
  logic [LANES-1:0]   be_q;
  logic [MA_W-1:0]    col_q;
  logic [BANKS-1:0]   bank_q;

  logic [MA_W-1:0]    ma_q;
  logic [IBANK_W-1:0] ba_q;
  logic [BANKS-1:0]   ras_n_q;
  logic [LANES-1:0]   cas_n_q;
  logic               we_n_q;
  logic               oe_q;
  logic [DATA_W-1:0]  dq_q;
  logic [LANES-1:0]   par_q;
  logic               rv_q;
  logic [DATA_W-1:0]  rdata_q;
  logic [LANES-1:0]   perr_q;
  logic               perr_any_q;

  dpc_addr_split #(
    .BANKS(BANKS), .MA_W(MA_W), .ROW_W(ROW_W), .COL_W(COL_W), .IBANK_W(IBANK_W)
  ) u_split (
    .addr(req_addr), .bank_oh(dec_bank), .row_ma(dec_row), .col_ma(dec_col), .ibank(dec_ib)
  );

  dpc_lane_parity #(.LANES(LANES)) u_wr_par (.data(req_wdata),  .odd_bit(wr_par));
  dpc_lane_parity #(.LANES(LANES)) u_rd_par (.data(dram_dq_in), .odd_bit(rd_par_calc));

  assign rd_err = rd_par_calc ^ dram_par_in;

  dpc_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk(clk), .rst(rst), .ack(ref_ack), .pending(ref_pend)
  );

  assign cnt_done  = (cnt == '0);
  assign ref_ack   = (st == S_IDLE) && ref_pend;
  assign req_ready = (st == S_IDLE) && !ref_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      cnt        <= '0;
      wr_q       <= 1'b0;
      be_q       <= '0;
      col_q      <= '0;
      bank_q     <= '0;
      ma_q       <= '0;
      ba_q       <= '0;
      ras_n_q    <= '1;
      cas_n_q    <= '1;
      we_n_q     <= 1'b1;
      oe_q       <= 1'b0;
      dq_q       <= '0;
      par_q      <= '0;
      rv_q       <= 1'b0;
      rdata_q    <= '0;
      perr_q     <= '0;
      perr_any_q <= 1'b0;
    end else begin
      rv_q       <= 1'b0;
      perr_any_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (ref_pend) begin
            cas_n_q <= '0;
            st      <= S_RCAS;
          end else if (req_valid) begin
            wr_q   <= req_write;
            be_q   <= req_be;
            col_q  <= dec_col;
            bank_q <= dec_bank;
            ma_q   <= dec_row;
            ba_q   <= dec_ib;
            dq_q   <= req_wdata;
            par_q  <= wr_par;
            st     <= S_ROW;
          end
        end
        S_ROW: begin
          ras_n_q <= ~bank_q;
          cnt     <= CNT_W'(T_RCD - 1);
          st      <= S_RCD;
        end
        S_RCD: begin
          if (cnt_done) begin
            ma_q    <= col_q;
            cas_n_q <= wr_q ? ~be_q : '0;
            we_n_q  <= ~wr_q;
            oe_q    <= wr_q;
            cnt     <= CNT_W'(T_CAS - 1);
            st      <= S_CAS;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_CAS: begin
          if (cnt_done) begin
            ras_n_q <= '1;
            cas_n_q <= '1;
            we_n_q  <= 1'b1;
            oe_q    <= 1'b0;
            if (!wr_q) begin
              rv_q       <= 1'b1;
              rdata_q    <= dram_dq_in;
              perr_q     <= rd_err;
              perr_any_q <= |rd_err;
            end
            cnt <= CNT_W'(T_RP - 1);
            st  <= S_PRE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_RCAS: begin
          ras_n_q <= '0;
          cnt     <= CNT_W'(T_REF_RAS - 1);
          st      <= S_RRAS;
        end
        S_RRAS: begin
          if (cnt_done) begin
            ras_n_q <= '1;
            cas_n_q <= '1;
            cnt     <= CNT_W'(T_RP - 1);
            st      <= S_PRE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_PRE: begin
          if (cnt_done) st <= S_IDLE;
          else          cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign dram_ma      = ma_q;
  assign dram_ba      = ba_q;
  assign dram_ras_n   = ras_n_q;
  assign dram_cas_n   = cas_n_q;
  assign dram_we_n    = we_n_q;
  assign dram_dq_oe   = oe_q;
  assign dram_dq_out  = dq_q;
  assign dram_par_out = par_q;
  assign rsp_valid    = rv_q;
  assign rsp_rdata    = rdata_q;
  assign rsp_perr     = perr_q;
  assign rsp_perr_any = perr_any_q;
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
  parameter int BANKS = 8,
  parameter int LANES = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_perr_any,
  input logic [BANKS-1:0] dram_ras_n,
  input logic [LANES-1:0] dram_cas_n,
  input logic             dram_we_n,
  input logic             dram_dq_oe
);
  // R2: an access lowers at most one row strobe; only refresh lowers all
  a_r2_single_bank: assert property (@(posedge clk) disable iff (rst)
    (dram_ras_n != '0) |-> ($countones(~dram_ras_n) <= 1));

  // R1: ready only with the array quiet
  a_r1_ready_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (dram_ras_n == '1 && dram_cas_n == '1));

  // R6: write enable only while the data bus is driven
  a_r6_we_drives: assert property (@(posedge clk) disable iff (rst)
    !dram_we_n |-> dram_dq_oe);

  // R8: response follows a full-width column pulse that has just ended
  a_r8_rsp_after_cas: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($past(dram_cas_n) == '0 && dram_cas_n == '1));

  // R9: no error summary without a response
  a_r9_err_quiet: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !rsp_perr_any);

  // R10: all-bank row strobe only after column strobes were already low
  a_r10_cbr_order: assert property (@(posedge clk) disable iff (rst)
    (dram_ras_n == '0) |-> ($past(dram_cas_n) == '0 && dram_we_n));
endmodule

bind dram_pm_ctrl dpc_checker #(.BANKS(BANKS), .LANES(LANES)) u_dpc_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_perr_any(rsp_perr_any), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
  .dram_we_n(dram_we_n), .dram_dq_oe(dram_dq_oe)
);

// File: tb/test_dram_pm_ctrl.sv
module test_dram_pm_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int T_RCD = 2, T_CAS = 2, T_RP = 2, T_REF_RAS = 3, REF_INT = 60;
  localparam int CAS_END = T_RCD + T_CAS;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [26:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [7:0]  req_be = '0;
  logic        rsp_valid, rsp_perr_any;
  logic [63:0] rsp_rdata;
  logic [7:0]  rsp_perr;
  logic [12:0] dram_ma;
  logic [1:0]  dram_ba;
  logic [7:0]  dram_ras_n, dram_cas_n, dram_par_out;
  logic        dram_we_n, dram_dq_oe;
  logic [63:0] dram_dq_out;
  logic [63:0] dram_dq_in = '0;
  logic [7:0]  dram_par_in = '0;

  dram_pm_ctrl #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_REF_RAS(T_REF_RAS),
                 .REF_INTERVAL(REF_INT)) i_dram_pm_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_perr(rsp_perr),
    .rsp_perr_any(rsp_perr_any), .dram_ma(dram_ma), .dram_ba(dram_ba),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_dq_oe(dram_dq_oe), .dram_dq_out(dram_dq_out), .dram_dq_in(dram_dq_in),
    .dram_par_out(dram_par_out), .dram_par_in(dram_par_in));

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] oddp(input logic [63:0] x);
    logic [7:0] p;
    for (int i = 0; i < 8; i++) p[i] = ~(^x[8*i +: 8]);
    return p;
  endfunction

  // stimulus for the memory side of the next read
  logic [63:0] rd_pat = '0;
  logic [7:0]  rd_par = '0;

  // behavioural reference model
  int          n = 0, start = 0, kind = 0, busy_end = 0;
  int          ref_count = 0, ref_over_req = 0;
  bit          m_pend = 0;
  logic        m_wr;
  logic [2:0]  m_bank;
  logic [12:0] m_row;
  logic [8:0]  m_col;
  logic [1:0]  m_ib;
  logic [7:0]  m_be, m_rdpar;
  logic [63:0] m_wd, m_rdpat;

  always @(posedge clk) begin
    if (rst) begin
      n = 0; kind = 0; busy_end = 0; m_pend = 0;
    end else begin
      n = n + 1;
      if (n - 1 >= busy_end) begin
        if (m_pend) begin
          kind = 3; start = n; busy_end = n + 1 + T_REF_RAS + T_RP;
          m_pend = 0; ref_count++;
          if (req_valid) ref_over_req++;
        end else if (req_valid) begin
          kind = req_write ? 2 : 1; start = n; busy_end = n + 1 + CAS_END + T_RP;
          m_wr = req_write; m_bank = req_addr[26:24]; m_row = req_addr[23:11];
          m_ib = req_addr[10:9]; m_col = req_addr[8:0]; m_be = req_be; m_wd = req_wdata;
          m_rdpat = rd_pat; m_rdpar = rd_par;
        end
      end
      if (n % REF_INT == 0) m_pend = 1;
    end
  end

  logic [7:0] e_ras, e_cas, e_perr;
  logic       e_we_n, e_oe, e_rv, e_rdy;
  int         d;
  string      tg;

  always @(negedge clk) begin
    d = n - start;
    e_ras = '1; e_cas = '1; e_we_n = 1'b1; e_oe = 1'b0; e_rv = 1'b0;
    e_rdy = (n >= busy_end) && !m_pend;
    tg = rst ? "R12" : "R4";
    if (!rst && (kind == 1 || kind == 2)) begin
      if (d >= 1 && d <= CAS_END) e_ras = ~(8'd1 << m_bank);
      if (d >= T_RCD + 1 && d <= CAS_END) begin
        e_cas = m_wr ? ~m_be : 8'h00;
        e_we_n = ~m_wr; e_oe = m_wr;
      end
      e_rv = !m_wr && (d == CAS_END + 1);
    end else if (!rst && kind == 3) begin
      tg = "R10";
      if (d >= 0 && d <= T_REF_RAS) e_cas = 8'h00;
      if (d >= 1 && d <= T_REF_RAS) e_ras = 8'h00;
    end
    chk(req_ready === e_rdy, (kind == 3) ? "R11" : "R1", 64'(req_ready), 64'(e_rdy));
    chk(dram_ras_n === e_ras, (kind == 3) ? tg : "R2", 64'(dram_ras_n), 64'(e_ras));
    chk(dram_cas_n === e_cas, (kind == 2) ? "R5" : tg, 64'(dram_cas_n), 64'(e_cas));
    chk(dram_we_n === e_we_n, "R6", 64'(dram_we_n), 64'(e_we_n));
    chk(dram_dq_oe === e_oe, "R6", 64'(dram_dq_oe), 64'(e_oe));
    chk(rsp_valid === e_rv, "R8", 64'(rsp_valid), 64'(e_rv));
    if (!rsp_valid) chk(rsp_perr_any === 1'b0, "R9", 64'(rsp_perr_any), 64'd0);
    if (!rst && (kind == 1 || kind == 2)) begin
      if (d >= 0 && d <= T_RCD) chk(dram_ma === m_row, "R3", 64'(dram_ma), 64'(m_row));
      if (d >= T_RCD + 1 && d <= CAS_END) chk(dram_ma === 13'(m_col), "R3", 64'(dram_ma), 64'(m_col));
      if (d >= 0 && d <= CAS_END) chk(dram_ba === m_ib, "R3", 64'(dram_ba), 64'(m_ib));
      if (e_oe) begin
        chk(dram_dq_out === m_wd, "R6", dram_dq_out, m_wd);
        chk(dram_par_out === oddp(m_wd), "R7", 64'(dram_par_out), 64'(oddp(m_wd)));
      end
      if (e_rv) begin
        e_perr = m_rdpar ^ oddp(m_rdpat);
        chk(rsp_rdata === m_rdpat, "R8", rsp_rdata, m_rdpat);
        chk(rsp_perr === e_perr, "R9", 64'(rsp_perr), 64'(e_perr));
        chk(rsp_perr_any === (e_perr != 0), "R9", 64'(rsp_perr_any), 64'(e_perr != 0));
      end
    end
    // memory side: correct word only in the last column cycle of a read
    if (!rst && kind == 1 && d == CAS_END) begin
      dram_dq_in = m_rdpat; dram_par_in = m_rdpar;
    end else begin
      dram_dq_in = ~m_rdpat; dram_par_in = ~m_rdpar;
    end
  end

  task automatic issue(input logic wr, input logic [26:0] a, input logic [63:0] wd,
                       input logic [7:0] be, input logic [63:0] pat, input logic [7:0] pmask);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
    rd_pat = pat; rd_par = oddp(pat) ^ pmask;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [26:0] mkaddr(input logic [2:0] b, input logic [12:0] r,
                                         input logic [1:0] ib, input logic [8:0] c);
    return {b, r, ib, c};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", n, 0);
    finish_run();
  end

  logic [31:0] seed = 32'h1234_5678;

  initial begin
    m_rdpat = '0; m_rdpar = '0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(dram_ras_n === 8'hFF && dram_cas_n === 8'hFF, "R12", {dram_ras_n, dram_cas_n}, 64'hFFFF);
    chk(dram_we_n === 1'b1 && dram_dq_oe === 1'b0, "R12", {dram_we_n, dram_dq_oe}, 64'b10);
    chk(req_ready === 1'b1 && rsp_valid === 1'b0, "R12", {req_ready, rsp_valid}, 64'b10);
    rst = 1'b0;
    // R2 R5 R6 R7: full and partial writes to distinct banks
    issue(1'b1, mkaddr(3'd0, 13'h1ABC, 2'd1, 9'h055), 64'h0123_4567_89AB_CDEF, 8'hFF, '0, '0);
    issue(1'b1, mkaddr(3'd5, 13'h0001, 2'd3, 9'h1FF), 64'hFFFF_0000_A5A5_0F0F, 8'h5A, '0, '0);
    issue(1'b1, mkaddr(3'd7, 13'h1FFF, 2'd0, 9'h000), 64'h8000_0000_0000_0001, 8'h81, '0, '0);
    // R8 R9: clean read, then reads with corrupted lanes
    issue(1'b0, mkaddr(3'd3, 13'h0F0F, 2'd2, 9'h100), 64'h0, 8'h00, 64'hDEAD_BEEF_CAFE_F00D, 8'h00);
    issue(1'b0, mkaddr(3'd7, 13'h0123, 2'd1, 9'h0AA), 64'h0, 8'h00, 64'h1111_2222_3333_4444, 8'h42);
    issue(1'b0, mkaddr(3'd1, 13'h0000, 2'd0, 9'h001), 64'h0, 8'h00, 64'h0, 8'hFF);
    // mixed traffic spanning several refresh intervals (R10 R11)
    for (int k = 0; k < 70; k++) begin
      logic [63:0] w;
      seed = seed * 32'd1103515245 + 32'd12345;
      w = {seed, ~seed ^ 32'(k)};
      issue(seed[31], seed[26:0], w, seed[15:8] | 8'h01, {w[31:0], w[63:32]},
            (k % 5 == 0) ? seed[7:0] : 8'h00);
    end
    // idle stretch: refreshes must run on their own (R10)
    repeat (3 * REF_INT) @(negedge clk);
    chk(ref_count >= 10, "R10", 64'(ref_count), 64'd10);
    chk(ref_over_req > 0, "R11", 64'(ref_over_req), 64'd1);
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule